// File: doc/BRIEF.md
# Dual Stack Pointer Engine

This block keeps two stack pointers, one for the system stack and one for the user stack, and turns push and pop requests into a sequence of single-byte memory transfers. Each stack has its own mode bit. With the bit at 1 the stack sits in the 8-bit register space: only the pointer's low byte is used and the high byte is left alone. With the bit at 0 the stack sits in the 16-bit data memory and the full two-byte pointer is used.

A push moves the pointer down first and then writes at the new address. A pop reads at the current address and then moves the pointer up. Word operations are split into two byte transfers on consecutive cycles. The high byte always ends up at the lower address. Every transfer carries a flag that names its target space, so the surrounding logic can route it to the register file or to data memory.

Software can load either byte of each pointer and both mode bits while the engine is idle. The pointers and mode bits can be read at all times on the output ports.

Top module: `stkptr_engine`

State machine:
- States:
  - `S_IDLE`: no transfer in progress.
  - `S_FIRST`: the first, or only, byte transfer.
  - `S_SECOND`: the second byte of a word operation.
- Transitions:
  - accept: `S_IDLE` to `S_FIRST`, when `req_valid` is seen in idle.
  - finish-byte: `S_FIRST` to `S_IDLE`.
  - continue-word: `S_FIRST` to `S_SECOND`.
  - finish-word: `S_SECOND` to `S_IDLE`.

## Requirements
- R1: After reset both mode bits read 1 (register space), both pointers read 0x0000, and `busy`, `op_done` and `xfer_en` are 0.
- R2: A byte push on a stack at pointer P makes one write transfer. The transfer goes to address P-1 with `req_wdata[7:0]`, and the pointer ends at P-1.
- R3: A byte pop on a stack at pointer P makes one read transfer at address P. The pointer ends at P+1 and `pop_data` becomes {0x00, byte read}. A pop leaves the stored data unchanged, so a repeated pop from the same pointer returns the same byte.
- R4: A word push at pointer P writes `req_wdata[7:0]` at P-1 and then `req_wdata[15:8]` at P-2, on consecutive cycles. The pointer ends at P-2, so the high byte sits at the lower address.
- R5: A word pop at pointer P reads the high byte at P and then the low byte at P+1. The pointer ends at P+2 and `pop_data` holds {high, low}.
- R6: In register mode, the transfer address is {0x00, low byte}. Pointer arithmetic wraps modulo 256 in the low byte only, the high byte keeps its value, and `xfer_mem` is 0.
- R7: In memory mode, the full 16-bit pointer is the address. Arithmetic wraps modulo 65536 and `xfer_mem` is 1.
- R8: `req_user` = 1 selects the user stack and 0 selects the system stack. The other stack's pointer is untouched. The mode bits are independent: bit 0 belongs to the system stack and bit 1 to the user stack.
- R9: A request seen in idle starts its first transfer in the next cycle, with one byte per cycle. `busy` is high exactly during the transfer cycles. `op_done` is high for one cycle, the cycle after the last transfer.
- R10: A request presented while `busy` is high is refused. It causes no transfer and no pointer change.
- R11: A software pointer write takes effect in the next cycle and only when idle. In `sw_ptr_sel`, bit 1 selects the user stack and bit 0 = 1 selects the low byte (0 selects the high byte). Pointer writes and mode writes presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_user | input | 1 | 1 = user stack, 0 = system stack |
| req_wdata | input | 16 | Push data |
| xfer_rdata | input | 8 | Read byte returned for the current read transfer |
| sw_ptr_wr | input | 1 | Software pointer byte write |
| sw_ptr_sel | input | 2 | Bit 1: user stack; bit 0: 1 = low byte, 0 = high byte |
| sw_wdata | input | 8 | Software pointer byte value |
| sw_mode_wr | input | 1 | Software mode write |
| sw_mode | input | 2 | New mode bits (bit 0 system, bit 1 user; 1 = register space) |
| busy | output | 1 | Transfer in progress |
| xfer_en | output | 1 | Byte transfer valid this cycle |
| xfer_wr | output | 1 | 1 = write, 0 = read |
| xfer_mem | output | 1 | 1 = data memory, 0 = register space |
| xfer_addr | output | 16 | Byte address |
| xfer_wdata | output | 8 | Write byte |
| pop_data | output | 16 | Result of the last pop |
| op_done | output | 1 | One-cycle pulse after the last transfer of an operation |
| sys_ptr | output | 16 | System stack pointer {high, low} |
| usr_ptr | output | 16 | User stack pointer {high, low} |
| stack_mode | output | 2 | Current mode bits |

## Verification
The bench targets the wrap of the low byte in register mode. A design that carried into the high byte would show a changed `sys_ptr[15:8]` and an address above 0x00FF. It also drives a 16-bit wrap from 0x0000 in memory mode, and pushes a word from 223 and pops it back. A swapped byte order would place 0x34 at 221 and return 0x3412. Requests, pointer writes and mode writes are injected mid-operation. A design that accepted any of them would show a second transfer, a pointer that moved twice, or a flipped mode bit. Random sequences then mix both stacks, both spaces and mode changes, checking every address against the bench model.

// File: rtl/stkptr_pkg.sv
`timescale 1ns/1ps
package stkptr_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FIRST  = 2'd1,
        S_SECOND = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic pop;
        logic word;
        logic user;
    } stk_op_t;

    localparam int STK_SYS = 0;
    localparam int STK_USR = 1;

endpackage

// File: rtl/stkptr_ptr.sv
`timescale 1ns/1ps
module stkptr_ptr #(
    parameter int BYTE_W = 8,
    localparam int PTR_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             mode_wdata,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic             step_en,
    input  logic             step_up,
    output logic             in_reg,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] push_addr,
    output logic [PTR_W-1:0] pop_addr
);
    logic [BYTE_W-1:0] hi_q, lo_q;
    logic              mode_q;
    logic [PTR_W-1:0]  full, full_dec, full_inc;
    logic [BYTE_W-1:0] lo_dec, lo_inc;

    always_comb begin
        full     = {hi_q, lo_q};
        full_dec = full - 1'b1;
        full_inc = full + 1'b1;
        lo_dec   = lo_q - 1'b1;
        lo_inc   = lo_q + 1'b1;
        // register space uses only the low byte, zero-extended
        push_addr = mode_q ? {{BYTE_W{1'b0}}, lo_dec} : full_dec;
        pop_addr  = mode_q ? {{BYTE_W{1'b0}}, lo_q}   : full;
        ptr       = full;
        in_reg    = mode_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            mode_q <= 1'b1;
        end else if (step_en) begin
            if (mode_q) begin
                lo_q <= step_up ? lo_inc : lo_dec;
            end else begin
                {hi_q, lo_q} <= step_up ? full_inc : full_dec;
            end
        end else begin
            if (hi_wr)   hi_q   <= wdata;
            if (lo_wr)   lo_q   <= wdata;
            if (mode_wr) mode_q <= mode_wdata;
        end
    end

endmodule

// File: rtl/stkptr_seq.sv
`timescale 1ns/1ps
module stkptr_seq
    import stkptr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int PTR_W = 2 * BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_pop,
    input  logic                  req_word,
    input  logic                  req_user,
    input  logic [PTR_W-1:0]      req_wdata,
    input  logic [BYTE_W-1:0]     rdata,
    input  logic [1:0][PTR_W-1:0] push_addr_v,
    input  logic [1:0][PTR_W-1:0] pop_addr_v,
    input  logic [1:0]            in_reg_v,
    output logic                  busy,
    output logic [1:0]            step_v,
    output logic                  step_up,
    output logic                  xfer_en,
    output logic                  xfer_wr,
    output logic                  xfer_mem,
    output logic [PTR_W-1:0]      xfer_addr,
    output logic [BYTE_W-1:0]     xfer_wdata,
    output logic [PTR_W-1:0]      pop_data,
    output logic                  op_done
);
    seq_state_t       state_q, state_d;
    stk_op_t          op_q;
    logic [PTR_W-1:0] wdata_q;
    logic             accept, last_xfer;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_FIRST;
            S_FIRST:  state_d = op_q.word ? S_SECOND : S_IDLE;
            S_SECOND: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != S_IDLE);
        accept     = (state_q == S_IDLE) && req_valid;
        last_xfer  = ((state_q == S_FIRST) && !op_q.word) || (state_q == S_SECOND);
        xfer_en    = busy;
        xfer_wr    = busy && !op_q.pop;
        xfer_mem   = !in_reg_v[op_q.user];
        xfer_addr  = op_q.pop ? pop_addr_v[op_q.user] : push_addr_v[op_q.user];
        // low byte goes out first, so it lands at the higher address
        xfer_wdata = (state_q == S_SECOND) ? wdata_q[PTR_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
        step_v     = '0;
        step_v[op_q.user] = busy;
        step_up    = op_q.pop;
    end

    // captured request and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            wdata_q  <= '0;
            pop_data <= '0;
            op_done  <= 1'b0;
        end else begin
            op_done <= last_xfer;
            if (accept) begin
                op_q    <= '{pop: req_pop, word: req_word, user: req_user};
                wdata_q <= req_wdata;
            end
            if (op_q.pop && state_q == S_FIRST) begin
                if (op_q.word) pop_data[PTR_W-1:BYTE_W] <= rdata;
                else           pop_data <= {{BYTE_W{1'b0}}, rdata};
            end
            if (op_q.pop && state_q == S_SECOND) begin
                pop_data[BYTE_W-1:0] <= rdata;
            end
        end
    end

endmodule

// File: rtl/stkptr_engine.sv
`timescale 1ns/1ps
module stkptr_engine
    import stkptr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int PTR_W = 2 * BYTE_W,
    localparam int N_STK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_pop,
    input  logic              req_word,
    input  logic              req_user,
    input  logic [PTR_W-1:0]  req_wdata,
    input  logic [BYTE_W-1:0] xfer_rdata,
    input  logic              sw_ptr_wr,
    input  logic [1:0]        sw_ptr_sel,
    input  logic [BYTE_W-1:0] sw_wdata,
    input  logic              sw_mode_wr,
    input  logic [1:0]        sw_mode,
    output logic              busy,
    output logic              xfer_en,
    output logic              xfer_wr,
    output logic              xfer_mem,
    output logic [PTR_W-1:0]  xfer_addr,
    output logic [BYTE_W-1:0] xfer_wdata,
    output logic [PTR_W-1:0]  pop_data,
    output logic              op_done,
    output logic [PTR_W-1:0]  sys_ptr,
    output logic [PTR_W-1:0]  usr_ptr,
    output logic [1:0]        stack_mode
);
    logic [N_STK-1:0][PTR_W-1:0] ptr_v, push_addr_v, pop_addr_v;
    logic [N_STK-1:0]            in_reg_v, step_v;
    logic                        step_up;

    stkptr_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_pop    (req_pop),
        .req_word   (req_word),
        .req_user   (req_user),
        .req_wdata  (req_wdata),
        .rdata      (xfer_rdata),
        .push_addr_v(push_addr_v),
        .pop_addr_v (pop_addr_v),
        .in_reg_v   (in_reg_v),
        .busy       (busy),
        .step_v     (step_v),
        .step_up    (step_up),
        .xfer_en    (xfer_en),
        .xfer_wr    (xfer_wr),
        .xfer_mem   (xfer_mem),
        .xfer_addr  (xfer_addr),
        .xfer_wdata (xfer_wdata),
        .pop_data   (pop_data),
        .op_done    (op_done)
    );

    for (genvar gi = 0; gi < N_STK; gi++) begin : g_stk
        logic sel_hit;
        assign sel_hit = sw_ptr_wr && !busy && (sw_ptr_sel[1] == gi[0]);

        stkptr_ptr #(.BYTE_W(BYTE_W)) u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_wr   (sw_mode_wr && !busy),
            .mode_wdata(sw_mode[gi]),
            .hi_wr     (sel_hit && !sw_ptr_sel[0]),
            .lo_wr     (sel_hit && sw_ptr_sel[0]),
            .wdata     (sw_wdata),
            .step_en   (step_v[gi]),
            .step_up   (step_up),
            .in_reg    (in_reg_v[gi]),
            .ptr       (ptr_v[gi]),
            .push_addr (push_addr_v[gi]),
            .pop_addr  (pop_addr_v[gi])
        );
    end

    assign sys_ptr    = ptr_v[STK_SYS];
    assign usr_ptr    = ptr_v[STK_USR];
    assign stack_mode = in_reg_v;

endmodule

// File: rtl/stkptr_engine_chk.sv
`timescale 1ns/1ps
module stkptr_engine_chk #(
    parameter int BYTE_W = 8,
    localparam int PTR_W = 2 * BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             xfer_en,
    input logic             xfer_wr,
    input logic             xfer_mem,
    input logic [PTR_W-1:0] xfer_addr,
    input logic             op_done,
    input logic [1:0]       stack_mode
);
    AST_REG_SPACE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en && !xfer_mem |-> xfer_addr[PTR_W-1:BYTE_W] == '0); // R6

    AST_PUSH_PAIR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en && xfer_wr && $past(xfer_en && xfer_wr) |->
        xfer_addr[BYTE_W-1:0] == $past(xfer_addr[BYTE_W-1:0]) - 1'b1); // R4

    AST_POP_PAIR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en && !xfer_wr && $past(xfer_en && !xfer_wr) |->
        xfer_addr[BYTE_W-1:0] == $past(xfer_addr[BYTE_W-1:0]) + 1'b1); // R5

    AST_SPACE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en && $past(xfer_en) |-> $stable(xfer_mem)); // R8

    AST_XFER_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> xfer_en); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !xfer_en); // R9

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> op_done); // R9

    AST_MODE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(stack_mode)); // R11

endmodule

bind stkptr_engine stkptr_engine_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .xfer_en   (xfer_en),
    .xfer_wr   (xfer_wr),
    .xfer_mem  (xfer_mem),
    .xfer_addr (xfer_addr),
    .op_done   (op_done),
    .stack_mode(stack_mode)
);

// File: tb/stkptr_engine_test.sv
`timescale 1ns/1ps
module stkptr_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_pop = 1'b0, req_word = 1'b0, req_user = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [7:0]  xfer_rdata = '0;
    logic        sw_ptr_wr = 1'b0;
    logic [1:0]  sw_ptr_sel = '0;
    logic [7:0]  sw_wdata = '0;
    logic        sw_mode_wr = 1'b0;
    logic [1:0]  sw_mode = '0;
    logic        busy, xfer_en, xfer_wr, xfer_mem, op_done;
    logic [15:0] xfer_addr, pop_data, sys_ptr, usr_ptr;
    logic [7:0]  xfer_wdata;
    logic [1:0]  stack_mode;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] m_ptr [2];
    logic        m_reg [2];
    logic [7:0]  act_mem [int];
    logic [7:0]  exp_mem [int];

    always #2.5 clk = ~clk;

    stkptr_engine uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pop(req_pop),
        .req_word(req_word), .req_user(req_user), .req_wdata(req_wdata),
        .xfer_rdata(xfer_rdata), .sw_ptr_wr(sw_ptr_wr), .sw_ptr_sel(sw_ptr_sel),
        .sw_wdata(sw_wdata), .sw_mode_wr(sw_mode_wr), .sw_mode(sw_mode),
        .busy(busy), .xfer_en(xfer_en), .xfer_wr(xfer_wr), .xfer_mem(xfer_mem),
        .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata), .pop_data(pop_data),
        .op_done(op_done), .sys_ptr(sys_ptr), .usr_ptr(usr_ptr), .stack_mode(stack_mode)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_push_addr(logic [15:0] p, logic rm);
        return rm ? {8'h00, p[7:0] - 8'd1} : p - 16'd1;
    endfunction

    function automatic logic [15:0] f_pop_addr(logic [15:0] p, logic rm);
        return rm ? {8'h00, p[7:0]} : p;
    endfunction

    function automatic logic [15:0] f_step(logic [15:0] p, logic rm, logic up);
        if (rm) return {p[15:8], up ? p[7:0] + 8'd1 : p[7:0] - 8'd1};
        return up ? p + 16'd1 : p - 16'd1;
    endfunction

    function automatic int f_key(logic mem, logic [15:0] a);
        return mem ? 32'h10000 + int'(a) : int'(a);
    endfunction

    function automatic logic [7:0] f_act(int k);
        return act_mem.exists(k) ? act_mem[k] : 8'h00;
    endfunction

    function automatic logic [7:0] f_exp(int k);
        return exp_mem.exists(k) ? exp_mem[k] : 8'h00;
    endfunction

    task automatic check_ptrs(input string rq);
        chk(rq, "sys_ptr", 32'(sys_ptr), 32'(m_ptr[0]));
        chk(rq, "usr_ptr", 32'(usr_ptr), 32'(m_ptr[1]));
        chk(rq, "stack_mode", 32'(stack_mode), 32'({m_reg[1], m_reg[0]}));
    endtask

    // aligned at a falling edge on entry and exit
    task automatic sw_ptr(input bit user, input bit low, input logic [7:0] d);
        sw_ptr_wr = 1'b1; sw_ptr_sel = {user, low}; sw_wdata = d;
        @(negedge clk);
        sw_ptr_wr = 1'b0;
        if (low) m_ptr[user][7:0] = d; else m_ptr[user][15:8] = d;
        check_ptrs("R11");
    endtask

    task automatic sw_set_mode(input logic [1:0] m);
        sw_mode_wr = 1'b1; sw_mode = m;
        @(negedge clk);
        sw_mode_wr = 1'b0;
        m_reg[0] = m[0]; m_reg[1] = m[1];
        check_ptrs("R8");
    endtask

    task automatic do_op(input bit pop, input bit word, input bit user,
                         input logic [15:0] wd, input bit poke);
        logic [15:0] p, ea, exp_pop;
        logic        rm;
        logic [7:0]  byt;
        string       rq, sp;
        int          nb;
        p  = m_ptr[user];
        rm = m_reg[user];
        nb = word ? 2 : 1;
        exp_pop = '0;
        rq = pop ? (word ? "R5" : "R3") : (word ? "R4" : "R2");
        sp = rm ? "R6" : "R7";
        req_valid = 1'b1; req_pop = pop; req_word = word; req_user = user; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int b = 0; b < nb; b++) begin
            ea = pop ? f_pop_addr(p, rm) : f_push_addr(p, rm);
            chk("R9", "xfer_en", 32'(xfer_en), 32'd1);
            chk("R9", "busy", 32'(busy), 32'd1);
            chk(rq, "xfer_wr", 32'(xfer_wr), 32'(!pop));
            chk(sp, "xfer_mem", 32'(xfer_mem), 32'(!rm));
            chk(rq, "xfer_addr", 32'(xfer_addr), 32'(ea));
            if (!pop) begin
                byt = (b == 0) ? wd[7:0] : wd[15:8];
                chk(rq, "xfer_wdata", 32'(xfer_wdata), 32'(byt));
                act_mem[f_key(xfer_mem, xfer_addr)] = xfer_wdata;
                exp_mem[f_key(!rm, ea)] = byt;
            end else begin
                xfer_rdata = f_act(f_key(xfer_mem, xfer_addr));
                byt = f_exp(f_key(!rm, ea));
                if (!word)       exp_pop = {8'h00, byt};
                else if (b == 0) exp_pop[15:8] = byt;
                else             exp_pop[7:0] = byt;
            end
            p = f_step(p, rm, pop);
            if (poke && b == 0) begin
                // R10: request while busy; R11: software writes while busy
                req_valid = 1'b1; req_pop = !pop; req_word = 1'b1; req_user = !user;
                sw_ptr_wr = 1'b1; sw_ptr_sel = {user, 1'b1}; sw_wdata = 8'hAA;
                sw_mode_wr = 1'b1; sw_mode = ~{m_reg[1], m_reg[0]};
            end
            @(negedge clk);
            if (poke && b == 0) begin
                req_valid = 1'b0; sw_ptr_wr = 1'b0; sw_mode_wr = 1'b0;
            end
        end
        m_ptr[user] = p;
        chk("R9", "busy after last", 32'(busy), 32'd0);
        chk("R9", "op_done pulse", 32'(op_done), 32'd1);
        if (pop) chk(rq, "pop_data", 32'(pop_data), 32'(exp_pop));
        check_ptrs(poke ? "R10" : rq);
        @(negedge clk);
        chk("R9", "op_done clears", 32'(op_done), 32'd0);
        chk("R10", "no extra start", 32'(busy), 32'd0);
        check_ptrs(poke ? "R11" : "R8");
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        m_ptr[0] = '0; m_ptr[1] = '0; m_reg[0] = 1'b1; m_reg[1] = 1'b1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "stack_mode", 32'(stack_mode), 32'd3);
        chk("R1", "sys_ptr", 32'(sys_ptr), 32'd0);
        chk("R1", "usr_ptr", 32'(usr_ptr), 32'd0);
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "op_done", 32'(op_done), 32'd0);
        chk("R1", "xfer_en", 32'(xfer_en), 32'd0);

        // R2: byte push at 220 writes 219
        sw_ptr(1'b0, 1'b1, 8'd220);
        do_op(1'b0, 1'b0, 1'b0, 16'h00C7, 1'b0);
        // R4: word push from 223 lands at 222 and 221
        sw_ptr(1'b1, 1'b1, 8'd223);
        do_op(1'b0, 1'b1, 1'b1, 16'h1234, 1'b0);
        chk("R4", "high byte at 221", 32'(f_act(221)), 32'h12);
        chk("R4", "low byte at 222", 32'(f_act(222)), 32'h34);
        // R5: word pop returns it
        do_op(1'b1, 1'b1, 1'b1, 16'h0000, 1'b0);
        // R3: byte pop at 189, then repeated pop of unchanged data
        sw_ptr(1'b0, 1'b1, 8'd189);
        do_op(1'b1, 1'b0, 1'b0, 16'h0000, 1'b0);
        sw_ptr(1'b0, 1'b1, 8'd219);
        do_op(1'b1, 1'b0, 1'b0, 16'h0000, 1'b0);
        sw_ptr(1'b0, 1'b1, 8'd219);
        do_op(1'b1, 1'b0, 1'b0, 16'h0000, 1'b0);
        chk("R3", "repeat pop value", 32'(pop_data), 32'h00C7);
        // R6: register-space wrap keeps high byte
        sw_ptr(1'b0, 1'b0, 8'h5A);
        sw_ptr(1'b0, 1'b1, 8'h00);
        do_op(1'b0, 1'b0, 1'b0, 16'h00E1, 1'b0);
        chk("R6", "high untouched", 32'(sys_ptr), 32'h5AFF);
        do_op(1'b1, 1'b0, 1'b0, 16'h0000, 1'b0);
        // R7: memory-space wrap from 0x0000
        sw_set_mode(2'b10);
        sw_ptr(1'b0, 1'b0, 8'h00);
        sw_ptr(1'b0, 1'b1, 8'h00);
        do_op(1'b0, 1'b1, 1'b0, 16'hBEEF, 1'b0);
        chk("R7", "sys_ptr wrapped", 32'(sys_ptr), 32'hFFFE);
        do_op(1'b1, 1'b1, 1'b0, 16'h0000, 1'b0);
        // R7: borrow across bytes on the user stack
        sw_set_mode(2'b00);
        sw_ptr(1'b1, 1'b0, 8'h12);
        sw_ptr(1'b1, 1'b1, 8'h00);
        do_op(1'b0, 1'b0, 1'b1, 16'h0077, 1'b0);
        chk("R7", "usr_ptr borrow", 32'(usr_ptr), 32'h11FF);
        // R10 / R11: requests and software writes during busy
        do_op(1'b0, 1'b1, 1'b1, 16'hA55A, 1'b1);
        do_op(1'b1, 1'b0, 1'b0, 16'h0000, 1'b1);
        sw_set_mode(2'b11);

        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom_range(0, 19));
            if (r == 0)      sw_set_mode(2'($urandom_range(0, 3)));
            else if (r == 1) sw_ptr(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                                    8'($urandom_range(0, 255)));
            else do_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)), 16'($urandom_range(0, 65535)),
                       r == 2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule